// File: doc/BRIEF.md
# Serial FIFO Event, Interrupt and DMA Request Unit

This block sits beside the transmit and receive FIFOs of a serial controller and turns their fill counts and access strobes into status flags, interrupt causes, a single interrupt line and two DMA request lines. The FIFO storage and the shift engine live elsewhere; they feed this unit their current fill levels, the push and pop strobes and a busy indication, and the unit hands back a gated push enable for each FIFO so that a write into a full FIFO is dropped.

Software reaches the unit through a small synchronous register bus with one-cycle read latency. It programs a transmit and a receive interrupt threshold, an interrupt mask, a DMA enable pair and a DMA watermark per direction. Overflow and underflow causes are sticky and are removed through a write-only clear bitmap. Threshold and watermark registers clamp at DEPTH-1, so software can discover the FIFO depth by writing increasing values until the readback stops following.

Register word addresses (4-bit): 0 status, 1 tx fill, 2 rx fill, 3 tx threshold, 4 rx threshold, 5 interrupt mask, 6 raw cause, 7 masked cause, 8 clear (reads 0), 9 DMA enable, 10 tx watermark, 11 rx watermark; other addresses read 0.

Top module: `fifo_event_unit`

## Requirements
- R1: After synchronous reset, thresholds, watermarks, mask, DMA enables and sticky causes are 0, and irq, tx_dma_req and rx_dma_req are low; read data appears on bus_rdata one clock after bus_addr is presented.
- R2: The status register (address 0) holds busy in bit 0, tx full (tx_level == DEPTH) in bit 1, tx empty in bit 2, rx empty in bit 3 and rx full in bit 4.
- R3: Addresses 1 and 2 return the present tx_level and rx_level.
- R4: A write to a threshold or watermark register (addresses 3, 4, 10, 11) with a value above DEPTH-1 stores DEPTH-1; values up to DEPTH-1 read back unchanged.
- R5: Raw cause bit 0 is 1 while tx_level <= tx threshold; raw cause bit 4 is 1 while rx_level > rx threshold.
- R6: A tx_push while tx_level == DEPTH sets sticky raw bit 1 and holds tx_push_ok low; an rx_push while rx_level == DEPTH sets sticky raw bit 3 and holds rx_push_ok low; pushes into a non-full FIFO pass and set nothing.
- R7: An rx_pop while rx_level == 0 sets sticky raw bit 2; a pop from a non-empty FIFO sets nothing.
- R8: Writing the clear register clears: bit 0 all sticky causes, bit 1 rx underflow, bit 2 rx overflow, bit 3 tx overflow; sticky causes otherwise hold, and an event in the same cycle as its clear wins.
- R9: The masked cause register equals raw AND mask (mask bit layout matches raw), and irq is the OR of the masked causes, registered one clock after the raw cause.
- R10: DMA enable bit 1 enables transmit requests; tx_dma_req is 1, one clock later, while enabled and tx_level <= tx watermark.
- R11: DMA enable bit 0 enables receive requests; rx_dma_req is 1, one clock later, while enabled and rx_level > rx watermark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| engine_busy | input | 1 | Serial engine busy |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| rx_level | input | LVL_W | Receive FIFO fill count |
| tx_push | input | 1 | Transmit FIFO write request |
| rx_push | input | 1 | Receive FIFO write request |
| rx_pop | input | 1 | Receive FIFO read request |
| tx_push_ok | output | 1 | Transmit write passed to storage |
| rx_push_ok | output | 1 | Receive write passed to storage |
| irq | output | 1 | Interrupt line |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Level-derived causes are combinational inside the unit, so the raw and masked cause registers reflect a new fill count on the next read, while irq and both DMA requests follow one clock edge after the input changes. Sticky causes are captured at the edge that sees the faulty push or pop, so irq reacts two edges after that strobe; push enables are combinational and are sampled in the same cycle as the push. The bench drives every input on the falling edge and samples after the number of rising edges above has passed, waiting two edges after any stimulus before checking irq or a request line, and every register read waits one edge for the registered read data.

// File: rtl/fevu_pkg.sv
package fevu_pkg;
  localparam int AW    = 4;
  localparam int CAUSE_N = 5;

  // cause bit positions (raw, mask and masked share them)
  localparam int C_TX_LOW  = 0;
  localparam int C_TX_OVF  = 1;
  localparam int C_RX_UNF  = 2;
  localparam int C_RX_OVF  = 3;
  localparam int C_RX_HIGH = 4;

  // status bit positions
  localparam int S_BUSY    = 0;
  localparam int S_TX_FULL = 1;
  localparam int S_TX_EMP  = 2;
  localparam int S_RX_EMP  = 3;
  localparam int S_RX_FULL = 4;

  // clear bitmap positions
  localparam int K_ALL    = 0;
  localparam int K_RX_UNF = 1;
  localparam int K_RX_OVF = 2;
  localparam int K_TX_OVF = 3;

  // DMA enable positions
  localparam int D_RX = 0;
  localparam int D_TX = 1;

  typedef enum logic [AW-1:0] {
    A_STAT  = 4'd0,
    A_TXLVL = 4'd1,
    A_RXLVL = 4'd2,
    A_TXTHR = 4'd3,
    A_RXTHR = 4'd4,
    A_MASK  = 4'd5,
    A_RAW   = 4'd6,
    A_MSTAT = 4'd7,
    A_CLR   = 4'd8,
    A_DMAEN = 4'd9,
    A_TXWM  = 4'd10,
    A_RXWM  = 4'd11
  } reg_addr_e;
endpackage

// File: rtl/fevu_regbank.sv
module fevu_regbank
  import fevu_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int DW    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [LVL_W-1:0]  tx_thr,
  output logic [LVL_W-1:0]  rx_thr,
  output logic [LVL_W-1:0]  tx_wm,
  output logic [LVL_W-1:0]  rx_wm,
  output logic [CAUSE_N-1:0] mask,
  output logic [1:0]        dma_en,
  output logic [3:0]        clr
);
  localparam int NLV = 4;
  localparam logic [AW-1:0] LV_ADDR [NLV] = '{A_TXTHR, A_RXTHR, A_TXWM, A_RXWM};
  localparam logic [LVL_W-1:0] LV_MAX = LVL_W'(DEPTH - 1);

  logic [LVL_W-1:0] lv_q [NLV];
  logic [LVL_W-1:0] wsat;

  // clamp a written level to the largest usable entry index
  always_comb begin
    if (wdata > DW'(DEPTH - 1)) wsat = LV_MAX;
    else                        wsat = wdata[LVL_W-1:0];
  end

  for (genvar g = 0; g < NLV; g++) begin : g_lv
    always_ff @(posedge clk) begin
      if (rst)                              lv_q[g] <= '0;
      else if (wr && addr == LV_ADDR[g])    lv_q[g] <= wsat;
    end
  end

  assign tx_thr = lv_q[0];
  assign rx_thr = lv_q[1];
  assign tx_wm  = lv_q[2];
  assign rx_wm  = lv_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      dma_en <= '0;
    end else if (wr) begin
      if (addr == A_MASK)  mask   <= wdata[CAUSE_N-1:0];
      if (addr == A_DMAEN) dma_en <= wdata[1:0];
    end
  end

  // clear strobes act on the same edge as the write
  assign clr = (wr && addr == A_CLR) ? wdata[3:0] : 4'b0;
endmodule

// File: rtl/fevu_sticky.sv
module fevu_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flag[g] <= 1'b0;
      else if (set[g]) flag[g] <= 1'b1;   // event beats clear
      else if (clr[g]) flag[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/fevu_req.sv
module fevu_req
  import fevu_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   tx_thr,
  input  logic [LVL_W-1:0]   rx_thr,
  input  logic [LVL_W-1:0]   tx_wm,
  input  logic [LVL_W-1:0]   rx_wm,
  input  logic [CAUSE_N-1:0] mask,
  input  logic [1:0]         dma_en,
  input  logic [2:0]         sticky,
  output logic [CAUSE_N-1:0] raw,
  output logic [CAUSE_N-1:0] masked,
  output logic               irq,
  output logic               tx_req,
  output logic               rx_req
);
  always_comb begin
    raw            = '0;
    raw[C_TX_LOW]  = (tx_level <= tx_thr);
    raw[C_TX_OVF]  = sticky[0];
    raw[C_RX_UNF]  = sticky[1];
    raw[C_RX_OVF]  = sticky[2];
    raw[C_RX_HIGH] = (rx_level > rx_thr);
  end

  assign masked = raw & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      tx_req <= 1'b0;
      rx_req <= 1'b0;
    end else begin
      irq    <= |masked;
      tx_req <= dma_en[D_TX] && (tx_level <= tx_wm);
      rx_req <= dma_en[D_RX] && (rx_level > rx_wm);
    end
  end
endmodule

// File: rtl/fifo_event_unit.sv
module fifo_event_unit
  import fevu_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             engine_busy,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_push,
  input  logic             rx_push,
  input  logic             rx_pop,
  output logic             tx_push_ok,
  output logic             rx_push_ok,
  output logic             irq,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic [LVL_W-1:0]   tx_thr_w, rx_thr_w, tx_wm_w, rx_wm_w;
  logic [CAUSE_N-1:0] mask_w, raw_w, masked_w;
  logic [1:0]         dma_en_w;
  logic [3:0]         clr_w;
  logic [2:0]         set_w, sclr_w, sticky_w;
  logic [4:0]         stat_w;
  logic               tx_full, rx_full;

  assign tx_full = (tx_level == FULL);
  assign rx_full = (rx_level == FULL);

  assign tx_push_ok = tx_push && !tx_full;
  assign rx_push_ok = rx_push && !rx_full;

  fevu_regbank #(.DEPTH(DEPTH), .LVL_W(LVL_W), .DW(DW)) regs_i (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .tx_thr(tx_thr_w), .rx_thr(rx_thr_w), .tx_wm(tx_wm_w), .rx_wm(rx_wm_w),
    .mask(mask_w), .dma_en(dma_en_w), .clr(clr_w)
  );

  // sticky order: 0 tx overflow, 1 rx underflow, 2 rx overflow
  assign set_w[0]  = tx_push && tx_full;
  assign set_w[1]  = rx_pop && (rx_level == '0);
  assign set_w[2]  = rx_push && rx_full;
  assign sclr_w[0] = clr_w[K_ALL] | clr_w[K_TX_OVF];
  assign sclr_w[1] = clr_w[K_ALL] | clr_w[K_RX_UNF];
  assign sclr_w[2] = clr_w[K_ALL] | clr_w[K_RX_OVF];

  fevu_sticky #(.N(3)) sticky_i (
    .clk(clk), .rst(rst), .set(set_w), .clr(sclr_w), .flag(sticky_w)
  );

  fevu_req #(.DEPTH(DEPTH), .LVL_W(LVL_W)) req_i (
    .clk(clk), .rst(rst),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr_w), .rx_thr(rx_thr_w), .tx_wm(tx_wm_w), .rx_wm(rx_wm_w),
    .mask(mask_w), .dma_en(dma_en_w), .sticky(sticky_w),
    .raw(raw_w), .masked(masked_w),
    .irq(irq), .tx_req(tx_dma_req), .rx_req(rx_dma_req)
  );

  always_comb begin
    stat_w            = '0;
    stat_w[S_BUSY]    = engine_busy;
    stat_w[S_TX_FULL] = tx_full;
    stat_w[S_TX_EMP]  = (tx_level == '0);
    stat_w[S_RX_EMP]  = (rx_level == '0);
    stat_w[S_RX_FULL] = rx_full;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_STAT:  bus_rdata <= DW'(stat_w);
        A_TXLVL: bus_rdata <= DW'(tx_level);
        A_RXLVL: bus_rdata <= DW'(rx_level);
        A_TXTHR: bus_rdata <= DW'(tx_thr_w);
        A_RXTHR: bus_rdata <= DW'(rx_thr_w);
        A_MASK:  bus_rdata <= DW'(mask_w);
        A_RAW:   bus_rdata <= DW'(raw_w);
        A_MSTAT: bus_rdata <= DW'(masked_w);
        A_DMAEN: bus_rdata <= DW'(dma_en_w);
        A_TXWM:  bus_rdata <= DW'(tx_wm_w);
        A_RXWM:  bus_rdata <= DW'(rx_wm_w);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/fifo_event_unit_chk.sv
module fifo_event_unit_chk #(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [3:0]       bus_addr,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_push,
  input logic             rx_pop,
  input logic             irq,
  input logic             tx_dma_req,
  input logic             rx_dma_req,
  input logic [4:0]       raw_w,
  input logic [4:0]       mask_w,
  input logic [1:0]       dma_en_w,
  input logic [LVL_W-1:0] rx_wm_w,
  input logic [LVL_W-1:0] tx_thr_w
);
  // R6
  txovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_push && tx_level == LVL_W'(DEPTH)) |=> raw_w[1]);
  // R7
  rxunf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_level == '0) |=> raw_w[2]);
  // R8
  txovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (raw_w[1] && !(bus_wr && bus_addr == 4'd8)) |=> raw_w[1]);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_w == '0) |=> !irq);
  // R10
  txreq_en_chk: assert property (@(posedge clk) disable iff (rst)
    !dma_en_w[1] |=> !tx_dma_req);
  // R11
  rxreq_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    rx_dma_req |-> ($past(rx_level) > $past(rx_wm_w)));
  // R4
  thr_range_chk: assert property (@(posedge clk) disable iff (rst)
    tx_thr_w < LVL_W'(DEPTH));
endmodule

bind fifo_event_unit fifo_event_unit_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .tx_level(tx_level), .rx_level(rx_level), .tx_push(tx_push), .rx_pop(rx_pop),
  .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
  .raw_w(raw_w), .mask_w(mask_w), .dma_en_w(dma_en_w), .rx_wm_w(rx_wm_w),
  .tx_thr_w(tx_thr_w)
);

// File: tb/fifo_event_unit_tb_top.sv
module fifo_event_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int LVL_W = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic engine_busy = 1'b0;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic tx_push = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic tx_push_ok, rx_push_ok, irq, tx_dma_req, rx_dma_req;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_event_unit #(.DEPTH(DEPTH), .LVL_W(LVL_W), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .engine_busy(engine_busy),
    .tx_level(tx_level), .rx_level(rx_level), .tx_push(tx_push),
    .rx_push(rx_push), .rx_pop(rx_pop), .tx_push_ok(tx_push_ok),
    .rx_push_ok(rx_push_ok), .irq(irq), .tx_dma_req(tx_dma_req),
    .rx_dma_req(rx_dma_req)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [DW-1:0] v);
    @(negedge clk);
    bus_addr = 4'(a);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 irq", int'(irq), 0);
    chk("R1 txreq", int'(tx_dma_req), 0);
    chk("R1 rxreq", int'(rx_dma_req), 0);
    rd_reg(0, rd); chk("R2 status at reset", int'(rd), 'h0C);
    rd_reg(6, rd); chk("R1 raw at reset", int'(rd), 'h01);
    rd_reg(3, rd); chk("R1 txthr at reset", int'(rd), 0);
    rd_reg(5, rd); chk("R1 mask at reset", int'(rd), 0);
  endtask

  task automatic t_sat();
    wr_reg(3, 31);    rd_reg(3, rd); chk("R4 txthr 31", int'(rd), 31);
    wr_reg(3, 32);    rd_reg(3, rd); chk("R4 txthr 32", int'(rd), 31);
    wr_reg(3, 'hFF);  rd_reg(3, rd); chk("R4 txthr ff", int'(rd), 31);
    wr_reg(11, 40);   rd_reg(11, rd); chk("R4 rxwm 40", int'(rd), 31);
    wr_reg(4, 5);     rd_reg(4, rd); chk("R4 rxthr 5", int'(rd), 5);
    wr_reg(3, 0); wr_reg(4, 0); wr_reg(11, 0);
  endtask

  task automatic t_levels();
    @(negedge clk); tx_level = 32; rx_level = 32; engine_busy = 1'b1;
    rd_reg(0, rd); chk("R2 full busy", int'(rd), 'h13);
    rd_reg(1, rd); chk("R3 tx fill", int'(rd), 32);
    rd_reg(2, rd); chk("R3 rx fill", int'(rd), 32);
    @(negedge clk); tx_level = 7; rx_level = 5;
    rd_reg(0, rd); chk("R2 partial", int'(rd), 'h01);
    rd_reg(2, rd); chk("R3 rx fill 5", int'(rd), 5);
    engine_busy = 1'b0;
  endtask

  task automatic t_thresh();
    wr_reg(3, 4); wr_reg(4, 3);
    @(negedge clk); tx_level = 5; rx_level = 3;
    rd_reg(6, rd); chk("R5 above tx thr, at rx thr", int'(rd) & 'h11, 'h00);
    @(negedge clk); tx_level = 4; rx_level = 4;
    rd_reg(6, rd); chk("R5 at tx thr, above rx thr", int'(rd) & 'h11, 'h11);
  endtask

  task automatic t_irq();
    wr_reg(5, 'h11); settle();
    rd_reg(7, rd); chk("R9 masked both", int'(rd), 'h11);
    chk("R9 irq on", int'(irq), 1);
    wr_reg(5, 'h10);
    @(negedge clk); rx_level = 3; settle();
    rd_reg(7, rd); chk("R9 masked off", int'(rd), 0);
    chk("R9 irq off", int'(irq), 0);
  endtask

  task automatic t_ovf();
    wr_reg(5, 'h02);
    @(negedge clk); tx_level = 31; tx_push = 1'b1;
    #1 chk("R6 push ok not full", int'(tx_push_ok), 1);
    @(negedge clk); tx_push = 1'b0; settle();
    rd_reg(6, rd); chk("R6 no ovf below full", int'(rd) & 'h0E, 0);
    @(negedge clk); tx_level = 32; tx_push = 1'b1;
    #1 chk("R6 push blocked full", int'(tx_push_ok), 0);
    @(negedge clk); tx_push = 1'b0; settle();
    rd_reg(6, rd); chk("R6 tx ovf sticky", int'(rd) & 'h0E, 'h02);
    chk("R9 irq from ovf", int'(irq), 1);
    @(negedge clk); rx_level = 32; rx_push = 1'b1;
    #1 chk("R6 rx push blocked", int'(rx_push_ok), 0);
    @(negedge clk); rx_push = 1'b0; settle();
    rd_reg(6, rd); chk("R6 rx ovf sticky", int'(rd) & 'h0E, 'h0A);
    wr_reg(8, 'h8);
    rd_reg(6, rd); chk("R8 clear tx ovf only", int'(rd) & 'h0E, 'h08);
    wr_reg(8, 'h4);
    rd_reg(6, rd); chk("R8 clear rx ovf", int'(rd) & 'h0E, 0);
    tx_level = 4; rx_level = 3;
  endtask

  task automatic t_unf();
    @(negedge clk); rx_level = 1; rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0; settle();
    rd_reg(6, rd); chk("R7 no unf non-empty", int'(rd) & 'h0E, 0);
    @(negedge clk); rx_level = 0; rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    tx_level = 32; tx_push = 1'b1;
    @(negedge clk); tx_push = 1'b0; settle();
    rd_reg(6, rd); chk("R7 unf sticky", int'(rd) & 'h0E, 'h06);
    wr_reg(8, 'h1);
    rd_reg(6, rd); chk("R8 clear all", int'(rd) & 'h0E, 0);
  endtask

  task automatic t_race();
    @(negedge clk);
    rx_level = 0; rx_pop = 1'b1;
    bus_wr = 1'b1; bus_addr = 4'd8; bus_wdata = 'h2;
    @(negedge clk); rx_pop = 1'b0; bus_wr = 1'b0;
    rd_reg(6, rd); chk("R8 event wins clear", int'(rd) & 'h04, 'h04);
    wr_reg(8, 'h2);
    rd_reg(6, rd); chk("R8 later clear", int'(rd) & 'h04, 0);
    tx_level = 4;
  endtask

  task automatic t_dma();
    wr_reg(10, 8); wr_reg(11, 10);
    @(negedge clk); tx_level = 8; rx_level = 11; settle();
    chk("R10 tx req disabled", int'(tx_dma_req), 0);
    chk("R11 rx req disabled", int'(rx_dma_req), 0);
    wr_reg(9, 'h2); settle();
    chk("R10 tx req at wm", int'(tx_dma_req), 1);
    chk("R11 rx req en off", int'(rx_dma_req), 0);
    rd_reg(9, rd); chk("R10 dma en readback", int'(rd), 2);
    @(negedge clk); tx_level = 9; settle();
    chk("R10 tx req above wm", int'(tx_dma_req), 0);
    wr_reg(9, 'h3); settle();
    chk("R11 rx req above wm", int'(rx_dma_req), 1);
    @(negedge clk); rx_level = 10; settle();
    chk("R11 rx req at wm", int'(rx_dma_req), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got=timeout exp=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sat();
    t_levels();
    t_thresh();
    t_irq();
    t_ovf();
    t_unf();
    t_race();
    t_dma();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule